// File: doc/BRIEF.md
# Register-Mapped SPI Master With Single-Word Buffering

This block is a serial-peripheral-interface master driven from a small 32-bit register bus. A host places a word in the transmit register. The block then shifts that word out on the serial data output. At the same time it shifts a word in from the serial data input. When the exchange finishes, the received word is held until the host reads it.

The transmit side has one holding register. The host can queue one word while the previous word is still shifting. Status flags show whether the host may write the next word, whether a received word is waiting, whether the engine is fully drained, and whether either direction has lost data.

A one-hot mask picks the slave to address, from up to NUM_SEL active-low select lines. The chosen line is asserted automatically for each word. A sticky force bit in the control register keeps it asserted between words. One interrupt output combines every flag whose enable bit is set.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, the status register (byte offset 8) reads 0x060, meaning transmit ready (bit 6) and shift-register empty (bit 5). In the same state the control register (offset 12) reads 0, every select line is high, the serial clock is low and the interrupt is low.
- R2: A write to offset 4 while transmit ready is set sends the low DATA_W bits of the written data, most significant bit first. It produces exactly DATA_W serial-clock pulses, with the clock idling low. Each clock level lasts CLK_DIV system cycles. The data output does not change while the clock is high (mode 0).
- R3: The serial input is sampled on each rising clock edge, most significant bit first. When the word completes, receive ready (status bit 7) is set, and offset 0 returns the received word zero-extended.
- R4: A read of offset 0 clears receive ready.
- R5: If a word completes while receive ready is still set and not being read, receive overrun (status bit 3) is set and offset 0 returns the newer word.
- R6: A write to offset 4 while transmit ready is low sets transmit overrun (status bit 4) and discards the written word. The word already held is still sent.
- R7: Status bit 8 is the OR of the two overrun flags. Any write to offset 8 clears both overrun flags.
- R8: Shift-register empty (status bit 5) is low while a word is held or shifting, and high otherwise.
- R9: Offset 20 holds a NUM_SEL-bit one-hot mask, and line k of the select output is driven low when mask bit k is set. When force (control bit 10) is clear, the masked line is low only while a word is shifting. When force is set, the line stays low continuously.
- R10: The interrupt output is high when any flag is set and its enable is set in the control register. The enables use the same bit positions as the flags: 3 receive overrun, 4 transmit overrun, 6 transmit ready, 7 receive ready, 8 error summary.
- R11: Only control bits 3, 4, 6, 7, 8 and 10 are stored, so writing all ones to offset 12 reads back 0x5D8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus access strobe for this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data to slaves |
| miso | input | 1 | Serial data from slaves |
| ss_n | output | NUM_SEL | Active-low slave select lines |
| irq | output | 1 | Interrupt request |

## Verification
The embedded assertions check several properties on every cycle:
- the clock stays low when idle, and the data line is steady across each rising edge;
- a finished word always follows a falling edge;
- a receive-data read clears the ready flag, and an overrun sets its flag;
- a status write clears both error flags;
- the empty flag stays low while shifting;
- a select line is released when a word ends without force.

Other behaviours can only be shown by the bench's scenarios:
- whether the serial bit order and the sampled word match the values the bench chose;
- whether a rejected transmit word is really absent from the line;
- whether the half-period length is right;
- how the interrupt output combines across many register settings.

// File: rtl/spi_host_pkg.sv
// Shared register offsets and flag positions for the SPI master.
// Assumes a 5-bit byte-offset bus address; positions are part of the host contract.
package spi_host_pkg;
    localparam logic [4:0] OFS_RXD  = 5'd0;
    localparam logic [4:0] OFS_TXD  = 5'd4;
    localparam logic [4:0] OFS_STAT = 5'd8;
    localparam logic [4:0] OFS_CTRL = 5'd12;
    localparam logic [4:0] OFS_SEL  = 5'd20;

    localparam int B_ROE   = 3;
    localparam int B_TOE   = 4;
    localparam int B_TMT   = 5;
    localparam int B_TRDY  = 6;
    localparam int B_RRDY  = 7;
    localparam int B_ERR   = 8;
    localparam int B_FORCE = 10;

    localparam logic [31:0] CTRL_WMASK = 32'h0000_05D8;
endpackage

// File: rtl/spi_host_shifter.sv
// Mode-0 shift engine: shifts one DATA_W word out MSB first and in on rising edges.
// Assumes start is only meaningful while busy is low; each clock level lasts CLK_DIV cycles.
module spi_host_shifter #(
    parameter int DATA_W  = 8,
    parameter int CLK_DIV = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              miso,
    output logic              busy,
    output logic              sclk,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
    localparam logic [CNT_W-1:0] BIT_LAST = CNT_W'(DATA_W - 1);

    logic [DIV_W-1:0]  div_cnt;
    logic [CNT_W-1:0]  bit_cnt;
    logic [DATA_W-1:0] tx_sh;
    logic [DATA_W-1:0] rx_sh;

    // Half-period pacing, edge generation, bit shifting and end-of-word pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sclk    <= 1'b0;
            done    <= 1'b0;
            div_cnt <= '0;
            bit_cnt <= '0;
            tx_sh   <= '0;
            rx_sh   <= '0;
        end else begin
            done <= 1'b0;
            if (!busy) begin
                if (start) begin
                    busy    <= 1'b1;
                    sclk    <= 1'b0;
                    tx_sh   <= tx_word;
                    div_cnt <= '0;
                    bit_cnt <= '0;
                end
            end else if (div_cnt == DIV_LAST) begin
                div_cnt <= '0;
                if (!sclk) begin
                    sclk  <= 1'b1;
                    rx_sh <= {rx_sh[DATA_W-2:0], miso};
                end else begin
                    sclk <= 1'b0;
                    if (bit_cnt == BIT_LAST) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        bit_cnt <= bit_cnt + 1'b1;
                        tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
        end
    end

    assign mosi    = tx_sh[DATA_W-1];
    assign rx_word = rx_sh;

    // R2
    idle_sclk_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sclk);
    // R2
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $rose(sclk)) |-> $stable(mosi));
    // R3
    done_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(sclk) && !sclk));
endmodule

// File: rtl/spi_host_regs.sv
// Register file: transmit holding word, receive latch, status flags, control, select mask, interrupt.
// Assumes one bus access per cycle; reads have a side effect only at the receive-data offset.
module spi_host_regs
    import spi_host_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int NUM_SEL = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic               shift_busy,
    input  logic               word_done,
    input  logic [DATA_W-1:0]  rx_word,
    output logic               start,
    output logic [DATA_W-1:0]  tx_word,
    output logic               force_sel,
    output logic [NUM_SEL-1:0] sel_mask,
    output logic               tmt,
    output logic               irq
);
    logic              hold_vld;
    logic [DATA_W-1:0] hold_q;
    logic [DATA_W-1:0] rx_q;
    logic              rx_rdy;
    logic              rx_ovr;
    logic              tx_ovr;
    logic [31:0]       ctrl_q;
    logic [31:0]       status;

    logic tx_wr, st_wr, ctrl_wr, sel_wr, rx_rd;

    // Decode of the bus strobe into per-register write and read events.
    always_comb begin
        tx_wr   = bus_en &&  bus_we && (bus_addr == OFS_TXD);
        st_wr   = bus_en &&  bus_we && (bus_addr == OFS_STAT);
        ctrl_wr = bus_en &&  bus_we && (bus_addr == OFS_CTRL);
        sel_wr  = bus_en &&  bus_we && (bus_addr == OFS_SEL);
        rx_rd   = bus_en && !bus_we && (bus_addr == OFS_RXD);
    end

    assign start   = hold_vld && !shift_busy;
    assign tx_word = hold_q;
    assign tmt     = !hold_vld && !shift_busy;

    // Transmit holding register: accept when empty, flag overrun when full, hand over on start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_vld <= 1'b0;
            hold_q   <= '0;
        end else begin
            if (start)
                hold_vld <= 1'b0;
            if (tx_wr && !hold_vld) begin
                hold_vld <= 1'b1;
                hold_q   <= bus_wdata[DATA_W-1:0];
            end
        end
    end

    // Receive latch and the two error flags; a set in the same cycle wins over a status-write clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_q   <= '0;
            rx_rdy <= 1'b0;
            rx_ovr <= 1'b0;
            tx_ovr <= 1'b0;
        end else begin
            if (st_wr) begin
                rx_ovr <= 1'b0;
                tx_ovr <= 1'b0;
            end
            if (tx_wr && hold_vld)
                tx_ovr <= 1'b1;
            if (word_done) begin
                rx_q   <= rx_word;
                rx_rdy <= 1'b1;
                if (rx_rdy && !rx_rd)
                    rx_ovr <= 1'b1;
            end else if (rx_rd) begin
                rx_rdy <= 1'b0;
            end
        end
    end

    // Control and select-mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            sel_mask <= '0;
        end else begin
            if (ctrl_wr)
                ctrl_q <= bus_wdata & CTRL_WMASK;
            if (sel_wr)
                sel_mask <= bus_wdata[NUM_SEL-1:0];
        end
    end

    // Status word assembly.
    always_comb begin
        status         = '0;
        status[B_ROE]  = rx_ovr;
        status[B_TOE]  = tx_ovr;
        status[B_TMT]  = tmt;
        status[B_TRDY] = !hold_vld;
        status[B_RRDY] = rx_rdy;
        status[B_ERR]  = rx_ovr || tx_ovr;
    end

    assign force_sel = ctrl_q[B_FORCE];
    assign irq = |(status & ctrl_q & ~(32'd1 << B_FORCE));

    // Read multiplexer by byte offset.
    always_comb begin
        case (bus_addr)
            OFS_RXD:  bus_rdata = 32'(rx_q);
            OFS_STAT: bus_rdata = status;
            OFS_CTRL: bus_rdata = ctrl_q;
            OFS_SEL:  bus_rdata = 32'(sel_mask);
            default:  bus_rdata = '0;
        endcase
    end

    // R4
    rx_read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_rd && !word_done) |=> !rx_rdy);
    // R5
    rx_overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_done && rx_rdy && !rx_rd) |=> rx_ovr);
    // R6
    tx_overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_wr && hold_vld) |=> tx_ovr);
    // R7
    status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr && !word_done && !tx_wr) |=> (!rx_ovr && !tx_ovr));
endmodule

// File: rtl/spi_host_ctrl.sv
// Top of the register-mapped SPI master: joins the register file, shift engine and select gating.
// Assumes a single clock domain and a synchronous active-low reset; DATA_W is 8 or 16.
module spi_host_ctrl #(
    parameter int DATA_W  = 8,
    parameter int NUM_SEL = 16,
    parameter int CLK_DIV = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [4:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               sclk,
    output logic               mosi,
    input  logic               miso,
    output logic [NUM_SEL-1:0] ss_n,
    output logic               irq
);
    logic              busy, done, start, force_sel, tmt;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic [NUM_SEL-1:0] sel_mask;

    spi_host_regs #(.DATA_W(DATA_W), .NUM_SEL(NUM_SEL)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .shift_busy(busy), .word_done(done), .rx_word(rx_word),
        .start(start), .tx_word(tx_word), .force_sel(force_sel),
        .sel_mask(sel_mask), .tmt(tmt), .irq(irq)
    );

    spi_host_shifter #(.DATA_W(DATA_W), .CLK_DIV(CLK_DIV)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .miso(miso), .busy(busy), .sclk(sclk), .mosi(mosi),
        .done(done), .rx_word(rx_word)
    );

    // Select gating: masked lines go low while shifting or while forced.
    assign ss_n = ~(sel_mask & {NUM_SEL{force_sel | busy}});

    // R8
    empty_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !tmt);
    // R9
    release_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy) && !force_sel) |-> (&ss_n));
endmodule

// File: tb/spi_host_ctrl_test.sv
// Bench for spi_host_ctrl: seeded random words and selects plus directed overrun, interrupt and force cases.
module spi_host_ctrl_test;
    localparam int W   = 8;
    localparam int NS  = 16;
    localparam int DIV = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_en = 1'b0;
    logic          bus_we = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          sclk, mosi, miso;
    logic [NS-1:0] ss_n;
    logic          irq;

    int n_tests = 0;
    int n_fail  = 0;

    spi_host_ctrl #(.DATA_W(W), .NUM_SEL(NS), .CLK_DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n), .irq(irq)
    );

    always #10 clk = ~clk;

    // Slave model: bit index advances on each falling edge, never reset (full words only).
    logic [15:0] slv_out = '0;
    int          fall_cnt = 0;
    always @(negedge sclk) fall_cnt++;
    assign miso = slv_out[(W-1) - (fall_cnt % W)];

    // Line monitor: captures MOSI and checks select at each rising edge.
    logic [31:0]   mon_cap = '0;
    int            rise_cnt = 0;
    int            mon_ss_err = 0;
    logic [NS-1:0] exp_ss = '1;
    always @(posedge sclk) begin
        #1;
        mon_cap = {mon_cap[30:0], mosi};
        rise_cnt++;
        if (ss_n !== exp_ss) mon_ss_err++;
    end

    // High-level duration of the serial clock, in system cycles.
    int hi_run = 0;
    int last_hi = 0;
    always @(posedge clk) begin
        if (sclk) hi_run <= hi_run + 1;
        else begin
            if (hi_run != 0) last_hi <= hi_run;
            hi_run <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic wait_flag(input int bitpos);
        logic [31:0] s;
        for (int i = 0; i < 2000; i++) begin
            bus_read(5'd8, s);
            if (s[bitpos]) return;
        end
        check(1'b0, "wait_flag timeout", 32'(bitpos), 32'(bitpos));
    endtask

    // Expected interrupt from flags and enables (R10).
    function automatic logic exp_irq(input logic [31:0] st, input logic [31:0] en);
        return |(st & en & 32'h0000_01D8);
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    initial begin
        logic [31:0] rd, st;
        int r0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        bus_read(5'd8, rd);
        check(rd == 32'h060, "R1 status after reset", rd, 32'h060);
        bus_read(5'd12, rd);
        check(rd == 32'h0, "R1 control after reset", rd, 32'h0);
        check(ss_n == '1 && sclk == 1'b0 && irq == 1'b0, "R1 pins after reset",
              {ss_n, 14'd0, sclk, irq}, {16'hFFFF, 16'h0});

        // R11 control storage
        bus_write(5'd12, 32'hFFFF_FFFF);
        bus_read(5'd12, rd);
        check(rd == 32'h5D8, "R11 control readback", rd, 32'h5D8);
        bus_write(5'd12, 32'h0);

        // R2 R3 R4 R9 random words
        for (int it = 0; it < 40; it++) begin
            logic [NS-1:0] mask;
            logic          frc;
            logic [31:0]   txw;
            mask = NS'(1) << ($urandom % NS);
            frc  = 1'($urandom % 2);
            txw  = $urandom;
            slv_out = 16'($urandom);
            bus_write(5'd20, 32'(mask));
            bus_write(5'd12, 32'(frc) << 10);
            @(negedge clk); #1;
            check(ss_n == (frc ? ~mask : '1), "R9 idle select", 32'(ss_n), 32'(frc ? ~mask : '1));
            exp_ss = ~mask;
            r0 = rise_cnt;
            bus_write(5'd4, txw);
            wait_flag(7);
            bus_read(5'd0, rd);
            check(rd == 32'(slv_out[W-1:0]), "R3 received word", rd, 32'(slv_out[W-1:0]));
            check(rise_cnt - r0 == W, "R2 pulse count", 32'(rise_cnt - r0), 32'(W));
            check(mon_cap[W-1:0] == txw[W-1:0], "R2 MSB-first output", 32'(mon_cap[W-1:0]), 32'(txw[W-1:0]));
            check(last_hi == DIV, "R2 half period", 32'(last_hi), 32'(DIV));
            bus_read(5'd8, rd);
            check(rd == 32'h060, "R4 status after read", rd, 32'h060);
        end
        bus_write(5'd12, 32'h0);

        // R9 force holds and release
        bus_write(5'd20, 32'h0000_0020);
        bus_write(5'd12, 32'h400);
        @(negedge clk); #1;
        check(ss_n == ~NS'(32'h20), "R9 forced select", 32'(ss_n), 32'(~NS'(32'h20)));
        bus_write(5'd12, 32'h0);
        @(negedge clk); #1;
        check(ss_n == '1, "R9 released select", 32'(ss_n), 32'hFFFF);
        exp_ss = ~NS'(32'h20);

        // R5 receive overrun, R7 clear, R10 overrun interrupt
        slv_out = 16'h00A5;
        bus_write(5'd4, 32'h11);
        wait_flag(7);
        slv_out = 16'h003C;
        bus_write(5'd4, 32'h22);
        wait_flag(3);
        bus_read(5'd8, rd);
        check(rd == 32'h1E8, "R5 status with overrun", rd, 32'h1E8);
        bus_read(5'd0, rd);
        check(rd == 32'h3C, "R5 newer word kept", rd, 32'h3C);
        bus_read(5'd8, st);
        check(st == 32'h168, "R7 error summary", st, 32'h168);
        bus_write(5'd12, 32'h008);
        @(negedge clk); #1;
        check(irq == exp_irq(st, 32'h008), "R10 overrun interrupt", 32'(irq), 32'(exp_irq(st, 32'h008)));
        bus_write(5'd8, 32'h0);
        bus_read(5'd8, rd);
        check(rd == 32'h060, "R7 status write clears", rd, 32'h060);
        check(irq == 1'b0, "R10 interrupt after clear", 32'(irq), 32'h0);
        bus_write(5'd12, 32'h0);

        // R6 transmit overrun discards third word, R8 empty flag
        slv_out = 16'h0081;
        r0 = rise_cnt;
        bus_write(5'd4, 32'hA1);
        bus_write(5'd4, 32'hB2);
        bus_write(5'd4, 32'hC3);
        bus_read(5'd8, rd);
        check((rd & 32'h170) == 32'h110, "R6 R8 status during shift", rd & 32'h170, 32'h110);
        wait_flag(7);
        bus_read(5'd0, rd);
        wait_flag(5);
        check(mon_cap[W-1:0] == 8'hB2, "R6 held word sent", 32'(mon_cap[W-1:0]), 32'hB2);
        check(rise_cnt - r0 == 2 * W, "R6 discarded word absent", 32'(rise_cnt - r0), 32'(2 * W));
        bus_read(5'd0, rd);
        bus_read(5'd8, rd);
        check(rd == 32'h170, "R6 overrun flag kept", rd, 32'h170);
        bus_write(5'd8, 32'hFFFF_FFFF);
        bus_read(5'd8, rd);
        check(rd == 32'h060, "R7 clear transmit overrun", rd, 32'h060);

        // R10 receive-ready and transmit-ready interrupts
        bus_write(5'd12, 32'h080);
        bus_write(5'd4, 32'h5A);
        wait_flag(7);
        @(negedge clk); #1;
        check(irq == 1'b1, "R10 receive-ready interrupt", 32'(irq), 32'h1);
        bus_read(5'd0, rd);
        @(negedge clk); #1;
        check(irq == 1'b0, "R10 interrupt after read", 32'(irq), 32'h0);
        bus_write(5'd12, 32'h040);
        @(negedge clk); #1;
        check(irq == 1'b1, "R10 transmit-ready interrupt", 32'(irq), 32'h1);
        bus_write(5'd12, 32'h0);

        check(mon_ss_err == 0, "R9 select during words", 32'(mon_ss_err), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule